// File: doc/BRIEF.md
# Serial Frame Receiver with Chain Output

This block receives writes on a three-wire serial port (active-low select, serial clock, data in) and turns them into parallel words for a command core. It runs on a system clock at least four times faster than the serial clock. All three serial lines pass through two-flop synchronisers, and edges are found in the system-clock domain. A data bit is captured on each falling serial-clock edge while select is low, most significant bit first.

A frame holds 24 bits. The upper 8 bits form a command byte and the lower 16 bits form a data halfword. When the 24th bit arrives, the word is presented with a single-cycle valid strobe. At the same moment the active-low chain output falls, so a second device whose select is wired to it starts its own frame with the bits that follow. The chain output rises again once this device's select returns high. A frame that ends early is dropped. Bits after the 24th are ignored until select rises. A configuration input from the command core can keep the chain output parked high.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `word_valid_o` is low, `chain_sel_n_o` is high, and no word is presented until a full frame arrives.
- R2: A bit is taken on each falling serial-clock edge while select is low, MSB first. Of the 24 bits, the first 8 form `word_cmd_o[7:0]` (first bit at bit 7) and the last 16 form `word_data_o[15:0]` (bit 8 of the frame at bit 15).
- R3: Each complete frame produces exactly one `word_valid_o` pulse of one system-clock cycle, a few cycles after the 24th falling edge.
- R4: If select rises before the 24th falling edge, no pulse is produced and the partial bits have no effect on any later word.
- R5: Falling edges after the 24th in the same select-low period are ignored: no second pulse appears, and the presented word holds the first 24 bits.
- R6: With chaining enabled (`chain_en_i` = 1), `chain_sel_n_o` stays high through the 23rd bit, goes low after the 24th falling edge, and returns high after select rises.
- R7: With `chain_en_i` = 0, `chain_sel_n_o` stays high throughout a frame.
- R8: Serial-clock and data activity while select is high has no effect: no pulse, and the chain output stays high.
- R9: The bit count restarts on every select falling edge, so back-to-back frames separated by a short select-high gap are each decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Serial select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| chain_en_i | input | 1 | 1 lets the chain output fall after a full frame |
| word_valid_o | output | 1 | One-cycle strobe for a received word |
| word_cmd_o | output | 8 | Command byte of the last received word |
| word_data_o | output | 16 | Data halfword of the last received word |
| chain_sel_n_o | output | 1 | Active-low select for the next device in the chain |

## Verification
The bench targets the frame boundaries. It sends a 10-bit frame, which a receiver without the abort would treat as the start of a later word, skewing that word's data. It sends a 30-bit frame, which a design that does not saturate its count would wrap into a second, spurious strobe or a shifted word. It probes the chain output both just before and just after the 24th edge, catching an off-by-one count or a release that never happens, and it repeats the frame with chaining disabled. Serial-clock toggling while select is high and back-to-back frames expose a counter that is not cleared per frame.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int CMD_W      = 8;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = CMD_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // positions in the synchronised line bundle
    localparam int LN_SEL = 2;
    localparam int LN_SCK = 1;
    localparam int LN_SDI = 0;
    localparam int LINES  = 3;

    // positions in the edge-event bundle
    localparam int EV_SEL_FALL = 2;
    localparam int EV_SEL_RISE = 1;
    localparam int EV_SCK_FALL = 0;
    localparam int EVENTS      = 3;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic frame_t split_word(input logic [FRAME_BITS-1:0] raw);
        frame_t f;
        f.cmd  = raw[FRAME_BITS-1 -: CMD_W];
        f.data = raw[DATA_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter logic [W-1:0] FALLING = '1  // per bit: 1 detects high-to-low, 0 low-to-high
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] event_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= level_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (FALLING[i]) begin : g_fall
            assign event_o[i] = prev_q[i] & ~level_i[i];
        end else begin : g_rise
            assign event_o[i] = ~prev_q[i] & level_i[i];
        end
    end
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift
    import sfr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_fall_i,
    input  logic   sel_rise_i,
    input  logic   sck_fall_i,
    input  logic   sdi_i,
    output logic   valid_o,
    output frame_t word_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0]      cnt_q;
    logic                  armed_q;
    logic [FRAME_BITS-2:0] shreg_q;
    logic                  take;

    assign take = armed_q && sck_fall_i && (cnt_q < FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            shreg_q <= '0;
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            if (sel_rise_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (sel_fall_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (take) begin
                shreg_q <= {shreg_q[FRAME_BITS-3:0], sdi_i};
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    valid_o <= 1'b1;
                    word_o  <= split_word({shreg_q, sdi_i});
                end
            end
        end
    end

    // R5: count never passes the frame length
    a_r5_count_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);
    // R4: a select rise closes the frame with no strobe
    a_r4_no_valid_after_abort: assert property (@(posedge clk) disable iff (rst)
        sel_rise_i |=> !valid_o);
    // R3: strobe lasts one cycle
    a_r3_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R2: presented word only changes with a strobe
    a_r2_word_stable_between: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(word_o) || $past(rst));
endmodule

// File: rtl/sfr_chain.sv
module sfr_chain (
    input  logic clk,
    input  logic rst,
    input  logic frame_done_i,
    input  logic sel_rise_i,
    input  logic chain_en_i,
    output logic chain_sel_n_o
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst)               hold_q <= 1'b0;
        else if (sel_rise_i)   hold_q <= 1'b0;
        else if (frame_done_i) hold_q <= 1'b1;
    end

    assign chain_sel_n_o = ~(hold_q & chain_en_i);

    // R6: the chain hold starts only from a completed frame
    a_r6_hold_from_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_q) |-> $past(frame_done_i));
    // R6: a select rise always releases the chain
    a_r6_release_on_rise: assert property (@(posedge clk) disable iff (rst)
        sel_rise_i |=> chain_sel_n_o);
    // R7: low chain output implies chaining is enabled
    a_r7_low_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !chain_sel_n_o |-> chain_en_i);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              chain_en_i,
    output logic              word_valid_o,
    output logic [CMD_W-1:0]  word_cmd_o,
    output logic [DATA_W-1:0] word_data_o,
    output logic              chain_sel_n_o
);
    logic [LINES-1:0]  lines_raw, lines_s;
    logic [EVENTS-1:0] ev_level, ev;
    frame_t            word;

    assign lines_raw[LN_SEL] = sel_n_i;
    assign lines_raw[LN_SCK] = sck_i;
    assign lines_raw[LN_SDI] = sdi_i;

    sfr_sync #(.W(LINES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .async_i(lines_raw), .sync_o(lines_s)
    );

    assign ev_level[EV_SEL_FALL] = lines_s[LN_SEL];
    assign ev_level[EV_SEL_RISE] = lines_s[LN_SEL];
    assign ev_level[EV_SCK_FALL] = lines_s[LN_SCK];

    sfr_edge #(.W(EVENTS), .RST_VAL(3'b110), .FALLING(3'b101)) u_edge (
        .clk(clk), .rst(rst), .level_i(ev_level), .event_o(ev)
    );

    sfr_shift u_shift (
        .clk(clk), .rst(rst),
        .sel_fall_i(ev[EV_SEL_FALL]), .sel_rise_i(ev[EV_SEL_RISE]),
        .sck_fall_i(ev[EV_SCK_FALL]), .sdi_i(lines_s[LN_SDI]),
        .valid_o(word_valid_o), .word_o(word)
    );

    sfr_chain u_chain (
        .clk(clk), .rst(rst),
        .frame_done_i(word_valid_o), .sel_rise_i(ev[EV_SEL_RISE]),
        .chain_en_i(chain_en_i), .chain_sel_n_o(chain_sel_n_o)
    );

    assign word_cmd_o  = word.cmd;
    assign word_data_o = word.data;

    // R8: no strobe while the synchronised select is high
    a_r8_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (lines_s[LN_SEL] && $past(lines_s[LN_SEL])) |-> !word_valid_o || $past(rst));
endmodule

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
    logic clk = 0;
    logic rst = 1;
    logic sel_n = 1, sck = 0, sdi = 0, chain_en = 1;
    logic        valid, chain_n;
    logic [7:0]  cmd;
    logic [15:0] data;
    int checks = 0, errors = 0, seen = 0, sent = 0;
    bit done = 0;
    logic [23:0] expq[$];

    always #10 clk = ~clk;

    serial_frame_rx u0 (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
        .chain_en_i(chain_en), .word_valid_o(valid), .word_cmd_o(cmd),
        .word_data_o(data), .chain_sel_n_o(chain_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    // Sends n bits (MSB of the n first) in one select-low period.
    task automatic send(input logic [31:0] bits, input int n, input bit full, input bit probe);
        if (full) begin expq.push_back(bits[n-1 -: 24]); sent++; end
        sel_n = 0; half();
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i]; sck = 1; half();
            sck = 0; half();
            if (probe && (n - 1 - i) == 22)      // R6: still high after 23rd bit
                check(chain_n == 1'b1, "R6 high before 24th", chain_n, 1);
            if (probe && (n - 1 - i) == 23)      // R6/R7: level after 24th bit
                check(chain_n == !chain_en, chain_en ? "R6 low after 24th" : "R7 disabled stays high",
                      chain_n, !chain_en);
        end
        sel_n = 1; half(); half();
        check(chain_n == 1'b1, "R6 released after select rise", chain_n, 1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && valid) begin
            seen++;
            if (expq.size() == 0) begin
                check(0, "R4/R5 unexpected strobe", {cmd, data}, 0);
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                check({cmd, data} == e, "R2 word", {cmd, data}, e);
                @(negedge clk);
                check(valid == 1'b0, "R3 single-cycle strobe", valid, 0);
            end
        end
    end

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(valid == 1'b0, "R1 valid low", valid, 0);
        check(chain_n == 1'b1, "R1 chain high", chain_n, 1);
        half();
        // R2/R3/R6 basic frames
        send({8'h00, 24'hA5_C3F0}, 24, 1, 1);
        send({8'h00, 24'h80_0001}, 24, 1, 1);
        send({8'h00, 24'h7F_FFFE}, 24, 1, 1);
        // R4 short frame discarded, then a full frame is unaffected
        send({22'h0, 10'h3FF}, 10, 0, 0);
        send({8'h00, 24'h12_3456}, 24, 1, 1);
        // R5 extra bits ignored
        send({2'b00, 24'h3C_9A5F, 6'b101011}, 30, 1, 1);
        // R7 chaining disabled
        chain_en = 0;
        send({8'h00, 24'hFF_0000}, 24, 1, 1);
        chain_en = 1;
        // R8 clock and data activity with select high
        for (int k = 0; k < 30; k++) begin
            sdi = k[0]; sck = 1; half(); sck = 0; half();
            if (k == 29) check(chain_n == 1'b1, "R8 chain high while deselected", chain_n, 1);
        end
        // R9 back-to-back frames with short gap
        send({8'h00, 24'h01_0203}, 24, 1, 0);
        send({8'h00, 24'hFE_DCBA}, 24, 1, 0);
        half();
        check(expq.size() == 0, "R3 every frame strobed", expq.size(), 0);
        check(seen == sent, "R4 R5 R8 strobe count", seen, sent);
        done = 1;
        report();
    end
endmodule